// File: doc/BRIEF.md
# Dual Event Trigger Sequencer

This block decides the moment an acquisition triggers. It runs in the sample-clock domain and takes two single-cycle event strobes, trigger 1 (`evt1`) and trigger 2 (`evt2`), from upstream qualifiers. It applies one rule at a time. The rule can fire on a single event. It can measure the time from trigger 1 to trigger 2 and test it against a lower limit, an upper limit or a window. It can count trigger 1 events. It can also wait for trigger 1 and then count trigger 2 events. When the chosen rule is met, the block emits a one-cycle trigger pulse. It then holds in a done state until it is armed again.

The configuration inputs select the mode, the two time limits in clock ticks and the event count. Keep them stable while the block is armed. The distance `d` between two events is the number of clock cycles from the cycle that carries `evt1` to the cycle that carries `evt2`.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, `trigOut`, `armed` and `done` are 0. No strobe produces a trigger until `armReq` is pulsed.
- R2: A cycle with `armReq` high sets `armed`=1 and `done`=0 in the next cycle, and clears the event count. Strobes in that same cycle are ignored.
- R3: With `mode` = 0 (single event), and also with the unused codes 6 and 7, an `evt1` seen while armed raises `trigOut` in the next cycle.
- R4: `trigOut` is high for exactly one cycle. In that cycle `done`=1 and `armed`=0.
- R5: With `mode` = 1 (shorter than minimum), an `evt2` at distance d < `minTicks` fires. An `evt2` with d ≥ `minTicks` does not fire, and neither does reaching d = `minTicks` without `evt2`. Either case returns the block to waiting for `evt1`.
- R6: With `mode` = 2 (window), an `evt2` with `minTicks` ≤ d ≤ `maxTicks` fires. An earlier `evt2` returns the block to waiting for `evt1`, and so does reaching d = `maxTicks` with no `evt2`.
- R7: With `mode` = 3 (longer than maximum), an `evt2` with d > `maxTicks` fires. An `evt2` with d ≤ `maxTicks` returns the block to waiting for `evt1`. There is no timeout; the timer saturates at its maximum value.
- R8: With `mode` = 4 (count trigger 1), the `countTarget`-th `evt1` after arming fires. A target of 0 behaves as 1.
- R9: With `mode` = 5 (sequenced count), `evt2` is ignored until an `evt1` has been seen. After that, the `countTarget`-th `evt2` fires, with a target of 0 behaving as 1.
- R10: While waiting for `evt2`, a new `evt1` restarts the timer or count from its own cycle. If an `evt2` in that same cycle qualifies, it fires first.
- R11: While `done` is high, `evt1` and `evt2` have no effect: no trigger fires and `done` stays high until `armReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armReq | input | 1 | One-cycle request to arm (or re-arm) |
| mode | input | 3 | Trigger rule code (0..5, see requirements) |
| minTicks | input | TIME_W (32) | Lower duration limit in clock ticks |
| maxTicks | input | TIME_W (32) | Upper duration limit in clock ticks |
| countTarget | input | CNT_W (31) | Number of events to count |
| evt1 | input | 1 | Trigger 1 event strobe |
| evt2 | input | 1 | Trigger 2 event strobe |
| trigOut | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | Block is waiting for its events |
| done | output | 1 | Block has fired and awaits re-arming |

## Verification
The bench probes the limits of each duration test on both sides. It uses d = `minTicks` - 1 against `minTicks` in the shorter-than mode, both window edges, and d = `maxTicks` against `maxTicks` + 1 in the longer-than mode. An off-by-one comparator or timer load would fire one tick early or miss an edge. It issues a second `evt1` partway through an interval and partway through a count; a design that failed to restart would fire at the wrong distance or count. It also sends strobes while done, while idle, and in the same cycle as `armReq`, where a leaky design would emit a spurious or second pulse. A zero count target is included, which a naive comparator would treat as never reached.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [2:0] {
    MODE_SINGLE = 3'd0,
    MODE_LT     = 3'd1,
    MODE_WIN    = 3'd2,
    MODE_GT     = 3'd3,
    MODE_CNT1   = 3'd4,
    MODE_SEQ    = 3'd5
  } trigMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2,
    ST_DONE  = 2'd3
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic timerLoad;
    logic cntClear;
    logic cntInc;
  } dpCmd_t;

  // datapath -> control comparison flags
  typedef struct packed {
    logic ltMin;
    logic gtMax;
    logic geMax;
    logic cntHit;
  } dpStat_t;

endpackage

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] minTicks,
  input  logic [TIME_W-1:0] maxTicks,
  input  logic [CNT_W-1:0]  countTarget,
  input  dpCmd_t            cmd,
  output dpStat_t           stat
);

  localparam logic [TIME_W-1:0] TIMER_MAX = {TIME_W{1'b1}};
  localparam logic [TIME_W-1:0] TIMER_ONE = TIME_W'(1);

  logic [TIME_W-1:0] timer;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W:0]    cntNext;

  // elapsed ticks since the latest trigger 1; saturates instead of wrapping
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (cmd.timerLoad) begin
      timer <= TIMER_ONE;
    end else if (timer != TIMER_MAX) begin
      timer <= timer + TIMER_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.cntClear) begin
      cnt <= '0;
    end else if (cmd.cntInc) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign cntNext = {1'b0, cnt} + (CNT_W + 1)'(1);

  always_comb begin
    stat.ltMin  = timer < minTicks;
    stat.gtMax  = timer > maxTicks;
    stat.geMax  = timer >= maxTicks;
    stat.cntHit = (countTarget == '0) || (cntNext >= {1'b0, countTarget});
  end

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armReq,
  input  logic [2:0] mode,
  input  logic       evt1,
  input  logic       evt2,
  input  dpStat_t    stat,
  output dpCmd_t     cmd,
  output logic       trigOut,
  output logic       armed,
  output logic       done
);

  seqState_e st, stNext;
  logic      fire;
  logic      isDur;
  logic      secondOk;
  trigMode_e modeE;

  assign modeE = trigMode_e'(mode);
  assign isDur = (modeE == MODE_LT) || (modeE == MODE_WIN) || (modeE == MODE_GT);

  // qualification of a trigger 2 against the running interval or count
  always_comb begin
    case (modeE)
      MODE_LT:  secondOk = stat.ltMin;
      MODE_WIN: secondOk = !stat.ltMin && !stat.gtMax;
      MODE_GT:  secondOk = stat.gtMax;
      MODE_SEQ: secondOk = stat.cntHit;
      default:  secondOk = 1'b0;
    endcase
  end

  always_comb begin
    stNext = st;
    fire   = 1'b0;
    cmd    = '0;
    if (armReq) begin
      stNext       = ST_WAIT1;
      cmd.cntClear = 1'b1;
    end else begin
      case (st)
        ST_WAIT1: begin
          if (evt1) begin
            if (modeE == MODE_CNT1) begin
              if (stat.cntHit) fire = 1'b1;
              else             cmd.cntInc = 1'b1;
            end else if (isDur || modeE == MODE_SEQ) begin
              stNext        = ST_WAIT2;
              cmd.timerLoad = 1'b1;
              cmd.cntClear  = 1'b1;
            end else begin
              fire = 1'b1;
            end
          end
        end
        ST_WAIT2: begin
          if (evt2 && secondOk) begin
            fire = 1'b1;
          end else if (evt1) begin
            cmd.timerLoad = 1'b1;
            cmd.cntClear  = 1'b1;
          end else if (evt2) begin
            if (modeE == MODE_SEQ) cmd.cntInc = 1'b1;
            else                   stNext = ST_WAIT1;
          end else if ((modeE == MODE_LT && !stat.ltMin) ||
                       (modeE == MODE_WIN && stat.geMax)) begin
            stNext = ST_WAIT1;
          end else if (!isDur && modeE != MODE_SEQ) begin
            stNext = ST_WAIT1;
          end
        end
        default: ;
      endcase
      if (fire) stNext = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      trigOut <= 1'b0;
    end else begin
      st      <= stNext;
      trigOut <= fire;
    end
  end

  assign armed = (st == ST_WAIT1) || (st == ST_WAIT2);
  assign done  = (st == ST_DONE);

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armReq,
  input  logic [2:0]        mode,
  input  logic [TIME_W-1:0] minTicks,
  input  logic [TIME_W-1:0] maxTicks,
  input  logic [CNT_W-1:0]  countTarget,
  input  logic              evt1,
  input  logic              evt2,
  output logic              trigOut,
  output logic              armed,
  output logic              done
);

  dpCmd_t  cmd;
  dpStat_t stat;

  trig_seq_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .armReq  (armReq),
    .mode    (mode),
    .evt1    (evt1),
    .evt2    (evt2),
    .stat    (stat),
    .cmd     (cmd),
    .trigOut (trigOut),
    .armed   (armed),
    .done    (done)
  );

  trig_seq_dp #(.TIME_W(TIME_W), .CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .minTicks    (minTicks),
    .maxTicks    (maxTicks),
    .countTarget (countTarget),
    .cmd         (cmd),
    .stat        (stat)
  );

endmodule

// File: rtl/trig_sequencer_chk.sv
module trig_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       armReq,
  input logic [2:0] mode,
  input logic       evt1,
  input logic       trigOut,
  input logic       armed,
  input logic       done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !done && !armReq) |=> (!armed && !done && !trigOut));

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rstN)
    armReq |=> (armed && !done && !trigOut));

  assert_single_fires_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !armReq && evt1 && mode == 3'd0) |=> trigOut);

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  assert_fire_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (done && !armed));

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !armReq) |=> (done && !trigOut));

endmodule

bind trig_sequencer trig_sequencer_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .armReq  (armReq),
  .mode    (mode),
  .evt1    (evt1),
  .trigOut (trigOut),
  .armed   (armed),
  .done    (done)
);

// File: tb/trig_sequencer_tb_top.sv
module trig_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armReq = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [31:0] minTicks = '0;
  logic [31:0] maxTicks = '0;
  logic [30:0] countTarget = '0;
  logic        evt1 = 1'b0;
  logic        evt2 = 1'b0;
  logic        trigOut, armed, done;

  int    checks = 0;
  int    errors = 0;
  bit    started = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  int     mSt = 0;     // 0 idle, 1 wait trigger 1, 2 wait trigger 2, 3 done
  longint mElap = 0;
  longint mCnt = 0;
  bit     expTrig = 1'b0;

  always #5 clk = ~clk;

  trig_sequencer dut_i (
    .clk(clk), .rstN(rstN), .armReq(armReq), .mode(mode),
    .minTicks(minTicks), .maxTicks(maxTicks), .countTarget(countTarget),
    .evt1(evt1), .evt2(evt2), .trigOut(trigOut), .armed(armed), .done(done)
  );

  always @(posedge clk) begin
    longint tgt, lo, hi;
    bit ld, ok, timedRule;
    tgt = (countTarget == 0) ? 1 : longint'(countTarget);
    lo  = longint'(minTicks);
    hi  = longint'(maxTicks);
    timedRule = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd3);
    ld = 1'b0;
    expTrig = 1'b0;
    if (!rstN) begin
      mSt = 0; mElap = 0; mCnt = 0;
    end else if (armReq) begin
      mSt = 1; mCnt = 0;
    end else if (mSt == 1) begin
      if (evt1) begin
        if (mode == 3'd4) begin
          mCnt++;
          if (mCnt >= tgt) begin mSt = 3; expTrig = 1'b1; end
        end else if (timedRule || mode == 3'd5) begin
          mSt = 2; ld = 1'b1; mCnt = 0;
        end else begin
          mSt = 3; expTrig = 1'b1;
        end
      end
    end else if (mSt == 2) begin
      case (mode)
        3'd1: ok = evt2 && (mElap < lo);
        3'd2: ok = evt2 && (mElap >= lo) && (mElap <= hi);
        3'd3: ok = evt2 && (mElap > hi);
        3'd5: ok = evt2 && (mCnt + 1 >= tgt);
        default: ok = 1'b0;
      endcase
      if (ok) begin
        mSt = 3; expTrig = 1'b1;
      end else if (evt1) begin
        ld = 1'b1; mCnt = 0;
      end else if (evt2) begin
        if (mode == 3'd5) mCnt++;
        else mSt = 1;
      end else if ((mode == 3'd1 && mElap >= lo) || (mode == 3'd2 && mElap >= hi)) begin
        mSt = 1;
      end else if (!timedRule && mode != 3'd5) begin
        mSt = 1;
      end
    end
    if (rstN) mElap = ld ? 1 : mElap + 1;
  end

  // compare against the reference on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      checks++;
      if (trigOut !== expTrig || armed !== (mSt == 1 || mSt == 2) || done !== (mSt == 3)) begin
        errors++;
        $display("FAIL %s: trig/armed/done actual %b%b%b expected %b%b%b at %0t",
                 curReq, trigOut, armed, done, expTrig, (mSt == 1 || mSt == 2), (mSt == 3), $time);
      end
    end
  end

  task automatic drive(input logic a, input logic e1, input logic e2);
    armReq = a; evt1 = e1; evt2 = e2;
    @(negedge clk);
    armReq = 1'b0; evt1 = 1'b0; evt2 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [2:0] m, input int mn, input int mx, input int ct);
    mode = m; minTicks = mn; maxTicks = mx; countTarget = ct[30:0];
    drive(1'b1, 1'b0, 1'b0);
  endtask

  // evt1, then evt2 at distance d cycles
  task automatic pair(input int d);
    drive(1'b0, 1'b1, 1'b0);
    idle(d - 1);
    drive(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (trigOut !== 1'b0 || armed !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %b%b%b expected 000", trigOut, armed, done);
    end
    started = 1'b1;

    curReq = "R1 strobes while idle";
    drive(1'b0, 1'b1, 1'b1); idle(2);

    curReq = "R3 single event";
    arm(3'd0, 0, 0, 0); idle(2); drive(1'b0, 1'b1, 1'b0); idle(3);

    curReq = "R11 strobes while done";
    drive(1'b0, 1'b1, 0); drive(1'b0, 0, 1'b1); drive(1'b0, 1'b1, 1'b1); idle(2);

    curReq = "R2 arm with same-cycle strobe";
    mode = 3'd0; drive(1'b1, 1'b1, 1'b0); idle(2);
    drive(1'b0, 1'b1, 1'b0); idle(2);

    curReq = "R3 unused code 6";
    arm(3'd6, 0, 0, 0); drive(1'b0, 1'b1, 1'b0); idle(2);

    curReq = "R5 below min fires";
    arm(3'd1, 5, 0, 0); pair(4); idle(2);
    curReq = "R5 at min rejected";
    arm(3'd1, 5, 0, 0); pair(5); idle(2);
    curReq = "R5 timeout rearms";
    drive(1'b0, 1'b1, 1'b0); idle(8); drive(1'b0, 0, 1'b1); idle(2);
    pair(1); idle(2);

    curReq = "R6 early evt2";
    arm(3'd2, 4, 8, 0); pair(3); idle(2);
    curReq = "R6 lower edge";
    pair(4); idle(2);
    curReq = "R6 upper edge";
    arm(3'd2, 4, 8, 0); pair(8); idle(2);
    curReq = "R6 past max";
    arm(3'd2, 4, 8, 0); pair(9); idle(3);

    curReq = "R7 at max rejected";
    arm(3'd3, 0, 6, 0); pair(6); idle(2);
    curReq = "R7 above max fires";
    pair(7); idle(2);
    curReq = "R7 long wait fires";
    arm(3'd3, 0, 6, 0); pair(50); idle(2);

    curReq = "R8 count three";
    arm(3'd4, 0, 0, 3);
    drive(1'b0, 1'b1, 0); idle(2); drive(1'b0, 0, 1'b1); drive(1'b0, 1'b1, 0); idle(1);
    drive(1'b0, 1'b1, 0); idle(2);
    curReq = "R8 zero target";
    arm(3'd4, 0, 0, 0); drive(1'b0, 1'b1, 0); idle(2);

    curReq = "R9 sequenced count";
    arm(3'd5, 0, 0, 4);
    drive(1'b0, 0, 1'b1); drive(1'b0, 0, 1'b1); idle(1);
    drive(1'b0, 1'b1, 0);
    for (int i = 0; i < 4; i++) begin drive(1'b0, 0, 1'b1); idle(1); end
    idle(2);
    curReq = "R9 zero target";
    arm(3'd5, 0, 0, 0); drive(1'b0, 1'b1, 0); drive(1'b0, 0, 1'b1); idle(2);

    curReq = "R10 count restart";
    arm(3'd5, 0, 0, 4);
    drive(1'b0, 1'b1, 0); drive(1'b0, 0, 1'b1); drive(1'b0, 0, 1'b1);
    drive(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin drive(1'b0, 0, 1'b1); idle(1); end
    idle(2);
    curReq = "R10 timer restart";
    arm(3'd2, 4, 8, 0);
    drive(1'b0, 1'b1, 0); idle(6); pair(4); idle(2);
    curReq = "R10 qualifying evt2 wins";
    arm(3'd2, 4, 8, 0);
    drive(1'b0, 1'b1, 0); idle(4); drive(1'b0, 1'b1, 1'b1); idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule